// File: doc/BRIEF.md
# Sliding-Window Row SAD Search Engine

This engine scores one 4x4 current block against all sixteen horizontal candidate positions of one search row, with horizontal displacements from -8 to +7 pixels. For each candidate it forms the sum of absolute differences (SAD) over the 16 pixel pairs. It then reports all sixteen totals, the index of the smallest total and that total.

The work is split across four SAD lanes that run in parallel. Each block row takes four steps. In the first step of a row, each lane reads four adjacent reference pixels straight from the incoming reference line. In each later step, the reference line held in a window register moves left by one pixel. The lanes therefore reuse pixels already inside the engine and fetch nothing a second time. Each lane produces one row-partial SAD per step, and that value is added into the buffer of the candidate it served. Four steps cover all sixteen candidates for one block row. Sixteen steps cover the whole block.

The engine drives `ref_row` to name the block row it is working on. The surrounding logic must place the matching 19-pixel reference line on `ref_line` in the same cycle.

Top module: `sad_row_search`

## Requirements
- R1: After reset, `busy` and `done` are 0, every field of `sad_flat` is 0 and `best_idx` and `best_sad` are 0.
- R2: A `start` sampled while idle sets `busy` for exactly 16 cycles. During those cycles `ref_row` equals the block row being processed, counting up 0, 1, 2, 3, and each value holds for 4 consecutive cycles.
- R3: Candidate c (0..15, displacement c-8) has a SAD equal to the sum over rows r and columns j (0..3) of |cur(r,j) - line_r(c+j)|. Current pixel (r,j) sits at bits [(4r+j)*8 +: 8] of `cur_blk`. Reference pixel i (0..18) of the line for row r sits at bits [8i +: 8] of `ref_line` while `ref_row` = r. SAD c is output at bits [12c +: 12] of `sad_flat`.
- R4: `done` is a one-cycle pulse. It is raised in the cycle that follows the 17th rising clock edge after the edge that accepted `start`.
- R5: When `done` is high, `best_idx` is the lowest candidate index whose SAD is minimal, and `best_sad` is that SAD.
- R6: A `start` raised while `busy` is high is ignored. It changes neither the timing nor the results of the running search.
- R7: An accepted `start` clears all sixteen SAD buffers, so a new search does not add onto the totals of the previous one.
- R8: After `done`, the values of `sad_flat`, `best_idx` and `best_sad` stay unchanged until the next accepted `start`.
- R9: Each SAD buffer is 12 bits wide and holds the largest possible total, 4080 (all pixel pairs 255 apart), without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; taken only while idle |
| cur_blk | input | 128 | Current 4x4 block, 8-bit pixels, row-major, sampled on start |
| ref_line | input | 152 | 19-pixel reference line for the row shown on ref_row |
| ref_row | output | 2 | Block row currently being processed |
| busy | output | 1 | High during the 16 accumulation steps |
| done | output | 1 | One-cycle pulse when results are final |
| sad_flat | output | 192 | Sixteen 12-bit SAD totals, candidate 0 in the low bits |
| best_idx | output | 4 | Lowest index of the minimal SAD |
| best_sad | output | 12 | Minimal SAD value |

## Verification
The assertions assume that `ref_line` follows `ref_row` in the same cycle and holds steady across all four steps of a row, because the window register is loaded only in the first step. The bench meets this by driving `ref_line` combinationally from its own per-row arrays, indexed by the `ref_row` value it observes. The assertions also assume that `cur_blk` is valid only in the cycle where `start` is accepted. The bench changes `cur_blk` only at falling edges and loads a new block only for a fresh search. Some stimulus is stray `start` pulses raised inside a run, which the control logic is expected to absorb without any effect.

// File: rtl/sad_pkg.sv
package sad_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } srch_state_t;

  // Absolute difference of two unsigned pixels (zero-extended to 16 bits).
  function automatic logic [15:0] pix_absdiff(input logic [15:0] a, input logic [15:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/sad_lane.sv
module sad_lane
  import sad_pkg::*;
#(
  parameter int PW = 8,
  parameter int BW = 4,
  localparam int USW = $clog2(BW * ((1 << PW) - 1) + 1)
) (
  input  logic [BW*PW-1:0] cur_row,
  input  logic [BW*PW-1:0] ref_seg,
  output logic [USW-1:0]   part_sad
);

  always_comb begin
    part_sad = '0;
    for (int j = 0; j < BW; j++) begin
      part_sad = part_sad + USW'(pix_absdiff(16'(cur_row[j*PW +: PW]),
                                             16'(ref_seg[j*PW +: PW])));
    end
  end

endmodule

// File: rtl/sad_pick.sv
module sad_pick #(
  parameter int NCAND = 16,
  parameter int SADW  = 12,
  localparam int IW   = $clog2(NCAND)
) (
  input  logic [NCAND*SADW-1:0] sads,
  output logic [IW-1:0]         min_idx,
  output logic [SADW-1:0]       min_val
);

  // Strict less-than while scanning upward keeps the lowest index on ties.
  always_comb begin
    min_idx = '0;
    min_val = sads[SADW-1:0];
    for (int c = 1; c < NCAND; c++) begin
      if (sads[c*SADW +: SADW] < min_val) begin
        min_val = sads[c*SADW +: SADW];
        min_idx = IW'(c);
      end
    end
  end

endmodule

// File: rtl/sad_row_search.sv
module sad_row_search
  import sad_pkg::*;
#(
  parameter int PW    = 8,
  parameter int BW    = 4,
  parameter int NCAND = 16,
  parameter int NUNIT = 4,
  localparam int PH    = NCAND / NUNIT,
  localparam int PHW   = (PH > 1) ? $clog2(PH) : 1,
  localparam int LINE  = NCAND + BW - 1,
  localparam int WL    = LINE - 1,
  localparam int NSTEP = BW * PH,
  localparam int CW    = $clog2(NSTEP),
  localparam int RW    = (BW > 1) ? $clog2(BW) : 1,
  localparam int IW    = $clog2(NCAND),
  localparam int SADW  = $clog2(BW * BW * ((1 << PW) - 1) + 1),
  localparam int USW   = $clog2(BW * ((1 << PW) - 1) + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [BW*BW*PW-1:0]   cur_blk,
  input  logic [LINE*PW-1:0]    ref_line,
  output logic [RW-1:0]         ref_row,
  output logic                  busy,
  output logic                  done,
  output logic [NCAND*SADW-1:0] sad_flat,
  output logic [IW-1:0]         best_idx,
  output logic [SADW-1:0]       best_sad
);

  srch_state_t              state;
  logic [CW-1:0]            step;
  logic [BW*BW*PW-1:0]      cur_q;
  logic [WL*PW-1:0]         win;
  logic [SADW-1:0]          sad_buf [NCAND];
  logic [USW-1:0]           part [NUNIT];
  logic [BW*PW-1:0]         cur_row;
  logic [PHW-1:0]           phase;
  logic [IW-1:0]            pick_idx;
  logic [SADW-1:0]          pick_val;

  // Named internal events
  wire start_take = start && (state == ST_IDLE);
  wire running    = (state == ST_RUN);
  wire last_step  = running && (step == CW'(NSTEP - 1));
  wire row_first  = (phase == '0);

  assign phase   = step[PHW-1:0];
  assign ref_row = RW'(step >> PHW);
  assign busy    = running;
  assign cur_row = cur_q[ref_row*BW*PW +: BW*PW];

  // Sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
      cur_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          step  <= '0;
          cur_q <= cur_blk;
        end
        ST_RUN: begin
          step <= step + 1'b1;
          if (last_step) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Reference window: loaded one pixel to the right at the first step of a row,
  // then moved left one pixel per step so lanes reuse held pixels.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= '0;
    end else if (running) begin
      if (row_first) win <= ref_line[LINE*PW-1:PW];
      else           win <= {PW'(0), win[WL*PW-1:PW]};
    end
  end

  // SAD lanes: lane u serves candidate u*PH + phase
  for (genvar u = 0; u < NUNIT; u++) begin : g_lane
    logic [BW*PW-1:0] ref_seg;
    always_comb begin
      for (int j = 0; j < BW; j++) begin
        ref_seg[j*PW +: PW] = row_first ? ref_line[(u*PH + j)*PW +: PW]
                                        : win[(u*PH + j)*PW +: PW];
      end
    end
    sad_lane #(.PW(PW), .BW(BW)) lane_i (
      .cur_row (cur_row),
      .ref_seg (ref_seg),
      .part_sad(part[u])
    );
  end

  // Candidate buffers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCAND; c++) sad_buf[c] <= '0;
    end else if (start_take) begin
      for (int c = 0; c < NCAND; c++) sad_buf[c] <= '0;
    end else if (running) begin
      for (int c = 0; c < NCAND; c++) begin
        if (phase == PHW'(c % PH))
          sad_buf[c] <= sad_buf[c] + SADW'(part[c / PH]);
      end
    end
  end

  for (genvar c = 0; c < NCAND; c++) begin : g_flat
    assign sad_flat[c*SADW +: SADW] = sad_buf[c];
  end

  sad_pick #(.NCAND(NCAND), .SADW(SADW)) pick_i (
    .sads   (sad_flat),
    .min_idx(pick_idx),
    .min_val(pick_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      best_idx <= '0;
      best_sad <= '0;
    end else begin
      done <= (state == ST_FIN);
      if (state == ST_FIN) begin
        best_idx <= pick_idx;
        best_sad <= pick_val;
      end
    end
  end

  // Assertions
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !row_first) |-> $stable(ref_row));

  assert_run_unbroken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !last_step) |=> busy);

  assert_hold_after_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(sad_flat) && $stable(best_idx));

  for (genvar c = 0; c < NCAND; c++) begin : g_chk
    assert_best_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (best_sad <= sad_flat[c*SADW +: SADW]));
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sad_flat[c*SADW +: SADW] <= SADW'(BW * BW * ((1 << PW) - 1)));
  end

endmodule

// File: tb/sad_row_search_tb_top.sv
module sad_row_search_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [127:0] cur_blk = '0;
  logic [151:0] ref_line;
  logic [1:0]   ref_row;
  logic         busy, done;
  logic [191:0] sad_flat;
  logic [3:0]   best_idx;
  logic [11:0]  best_sad;

  int cur_px [16];
  int ref_px [4][19];
  int exp_sad [16];
  int exp_best, exp_bval;
  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sad_row_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cur_blk(cur_blk),
    .ref_line(ref_line), .ref_row(ref_row), .busy(busy), .done(done),
    .sad_flat(sad_flat), .best_idx(best_idx), .best_sad(best_sad)
  );

  // Reference line follows the requested row.
  always_comb begin
    for (int i = 0; i < 19; i++) ref_line[i*8 +: 8] = 8'(ref_px[ref_row][i]);
  end

  task automatic chk(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic void model();
    exp_best = 0;
    exp_bval = 1 << 30;
    for (int c = 0; c < 16; c++) begin
      int s = 0;
      for (int r = 0; r < 4; r++)
        for (int j = 0; j < 4; j++) begin
          int d = cur_px[r*4+j] - ref_px[r][c+j];
          s += (d < 0) ? -d : d;
        end
      exp_sad[c] = s;
      if (s < exp_bval) begin exp_bval = s; exp_best = c; end
    end
  endfunction

  task automatic check_results(input string tag);
    for (int c = 0; c < 16; c++)
      chk(int'(sad_flat[c*12 +: 12]), exp_sad[c], {tag, " R3 R7 R9 sad"});
    chk(int'(best_idx), exp_best, {tag, " R5 best_idx"});
    chk(int'(best_sad), exp_bval, {tag, " R5 best_sad"});
  endtask

  // One search; a stray start is raised at step inj (0 = none).
  task automatic run_search(input string tag, input int inj);
    int done_at = -1;
    model();
    @(negedge clk);
    for (int i = 0; i < 16; i++) cur_blk[i*8 +: 8] = 8'(cur_px[i]);
    start = 1'b1;
    for (int k = 1; k <= 24; k++) begin
      @(negedge clk);
      start = (inj != 0 && k == inj) ? 1'b1 : 1'b0;
      cur_blk = ~cur_blk;
      if (k <= 16) begin
        chk(int'(busy), 1, {tag, " R2 R6 busy"});
        chk(int'(ref_row), (k - 1) / 4, {tag, " R2 ref_row"});
      end else if (k == 17) begin
        chk(int'(busy), 0, {tag, " R2 busy end"});
      end
      if (done) begin
        if (done_at < 0) done_at = k;
        else chk(k, done_at, {tag, " R4 done pulse"});
      end
      if (k == 18) check_results(tag);
    end
    chk(done_at, 18, {tag, " R4 done cycle"});
    check_results({tag, " R8 hold"});
    chk(int'(done), 0, {tag, " R4 done low"});
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) cur_px[i] = 0;
    for (int r = 0; r < 4; r++) for (int i = 0; i < 19; i++) ref_px[r][i] = 0;
    #23 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(int'(busy), 0, "R1 busy");
    chk(int'(done), 0, "R1 done");
    chk((sad_flat == '0) ? 1 : 0, 1, "R1 sad_flat zero");
    chk(int'(best_idx), 0, "R1 best_idx");
    chk(int'(best_sad), 0, "R1 best_sad");

    // Random patterns
    for (int t = 0; t < 4; t++) begin
      for (int i = 0; i < 16; i++) cur_px[i] = int'($urandom_range(255));
      for (int r = 0; r < 4; r++) for (int i = 0; i < 19; i++) ref_px[r][i] = int'($urandom_range(255));
      run_search("random", 0);
    end

    // Extreme difference: all 4080, tie at index 0
    for (int i = 0; i < 16; i++) cur_px[i] = 255;
    for (int r = 0; r < 4; r++) for (int i = 0; i < 19; i++) ref_px[r][i] = 0;
    run_search("max R9", 0);

    // Uniform: all zero, tie resolves to 0 (and R7: no carry-over from 4080s)
    for (int i = 0; i < 16; i++) cur_px[i] = 77;
    for (int r = 0; r < 4; r++) for (int i = 0; i < 19; i++) ref_px[r][i] = 77;
    run_search("uniform R5 R7", 0);

    // Planted exact match at every candidate position
    for (int p = 0; p < 16; p++) begin
      for (int i = 0; i < 16; i++) cur_px[i] = 10 + i;
      for (int r = 0; r < 4; r++) begin
        for (int i = 0; i < 19; i++) ref_px[r][i] = 200;
        for (int j = 0; j < 4; j++) ref_px[r][p+j] = cur_px[r*4+j];
      end
      run_search("planted R5", 0);
      chk(int'(best_idx), p, "planted R5 position");
    end

    // Two exact matches: lower index wins
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 19; i++) ref_px[r][i] = 200;
      for (int j = 0; j < 4; j++) begin
        ref_px[r][5+j] = cur_px[r*4+j];
        ref_px[r][11+j] = cur_px[r*4+j];
      end
    end
    run_search("tie R5", 0);
    chk(int'(best_idx), 5, "tie R5 lowest index");

    // Stray start mid-run
    for (int i = 0; i < 16; i++) cur_px[i] = int'($urandom_range(255));
    for (int r = 0; r < 4; r++) for (int i = 0; i < 19; i++) ref_px[r][i] = int'($urandom_range(255));
    run_search("stray start R6", 6);
    run_search("stray start late R6", 15);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule